// File: doc/BRIEF.md
# Context-Tagged Address Translation Buffer

This block is a small fully associative store of recent page translations. Every entry is tagged with a process context number and a 20-bit virtual page number, so translations for several processes can be held at once. A lookup presents a context, a 32-bit virtual address (upper 20 bits are the page, lower 12 bits the offset within a 4 KB page) and an access kind. One cycle later the block reports a hit with a 36-bit physical address, a miss that tells a table walker to index the page table, or a permission fault.

After a miss the walker loads the walked entry through the refill port. The kernel can drop every entry at once or drop the one entry that matches a given context and page. Both commands take one cycle.

The result is held in a small response state machine with four states: RSP_IDLE (no result this cycle), RSP_HIT, RSP_MISS and RSP_FAULT. The state is reloaded every cycle. With no request it moves to RSP_IDLE. With a request it moves to RSP_MISS when no tag matches or when a write finds an unmodified page, to RSP_FAULT when the permission bit for the access kind is clear, and to RSP_HIT otherwise. The outputs are decoded from the state.

Top module: `ctx_tlb`

## Requirements
- R1: After reset all entries are invalid and no result is reported. A request in cycle n gives a result in cycle n+1, with `rs_valid` high and exactly one of `rs_hit`, `rs_miss` or `rs_fault` high. With no request, `rs_valid` is low the next cycle.
- R2: A lookup matches an entry only when both the context and the page number are equal. On a hit, `rs_paddr` is the stored 24-bit frame number followed by the 12 offset bits of the request, and `rs_cacheable` gives the stored cacheable bit.
- R3: A lookup that matches no valid entry reports a miss. Every result, whatever its kind, returns the request's context on `rs_ctx` and its page number on `rs_vpn`.
- R4: The 3-bit permission code has bit 0 for read, bit 1 for write and bit 2 for execute. Access kind 0 is read, 1 is write, 2 is execute and 3 is reserved. A matching lookup whose access bit is clear, and any matching lookup of kind 3, reports a fault.
- R5: A permitted write that matches an entry whose modified bit is clear reports a miss, not a hit.
- R6: A refill whose tag is not present goes into the lowest-numbered invalid entry when one exists.
- R7: When every entry is valid, a refill with a new tag replaces the entry at a round-robin pointer. The pointer advances by one, wrapping from the last entry to 0, on every refill that allocates an entry, whichever entry was used.
- R8: A refill whose context and page already match a valid entry overwrites that entry in place and leaves the pointer unchanged.
- R9: Invalidate-all clears every entry in one cycle. Any refill presented in the same cycle as an invalidate command is dropped.
- R10: Invalidate-one clears only the entry matching both the given context and the given page. Entries with the same page and another context stay valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ctx | input | 8 | Lookup context |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| fl_valid | input | 1 | Refill request |
| fl_ctx | input | 8 | Refill context |
| fl_vpn | input | 20 | Refill page number |
| fl_pfn | input | 24 | Refill frame number |
| fl_perm | input | 3 | Refill permission code |
| fl_cach | input | 1 | Refill cacheable bit |
| fl_mod | input | 1 | Refill modified bit |
| iv_all | input | 1 | Invalidate every entry |
| iv_one | input | 1 | Invalidate the entry matching iv_ctx and iv_vpn |
| iv_ctx | input | 8 | Context for invalidate-one |
| iv_vpn | input | 20 | Page for invalidate-one |
| rs_valid | output | 1 | A result is present |
| rs_hit | output | 1 | Translation hit |
| rs_miss | output | 1 | Miss; walk needed |
| rs_fault | output | 1 | Permission fault |
| rs_paddr | output | 36 | Physical address on hit, else zero |
| rs_cacheable | output | 1 | Cacheable bit on hit |
| rs_ctx | output | 8 | Context of the answered request |
| rs_vpn | output | 20 | Page number of the answered request |

## Verification
A wrong valid bit or tag shows up on the next lookup of that tag: a hit turns into a miss, or a miss into a hit, one cycle after the request. A wrong round-robin pointer does not show at once. It becomes visible only when the table is full and a refill evicts the wrong entry, so the bench fills the table, overwrites an entry in place, and then probes which old tag has gone. Stale permission or modified bits show as a wrong hit/fault/miss kind on the first access of the affected type.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;
    localparam logic [1:0] ACC_RSVD  = 2'd3;

    localparam int PERM_W     = 3;
    localparam int PERM_RD    = 0;
    localparam int PERM_WR    = 1;
    localparam int PERM_EX    = 2;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_MISS  = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_state_t;

endpackage

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match #(
    parameter int N     = 8,
    parameter int CTX_W = 8,
    parameter int VPN_W = 20
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][CTX_W-1:0] ctx_arr,
    input  logic [N-1:0][VPN_W-1:0] vpn_arr,
    input  logic [CTX_W-1:0]        key_ctx,
    input  logic [VPN_W-1:0]        key_vpn,
    output logic [N-1:0]            hit_vec
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g]
                          && (ctx_arr[g] == key_ctx)
                          && (vpn_arr[g] == key_vpn);
    end

endmodule

// File: rtl/ctx_tlb_victim.sv
module ctx_tlb_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             alloc,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        victim_idx = free_any ? free_idx : rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (alloc) begin
            if (rr_ptr == IDX_W'(N - 1)) begin
                rr_ptr <= '0;
            end else begin
                rr_ptr <= rr_ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctx_tlb_store.sv
module ctx_tlb_store #(
    parameter int N      = 8,
    parameter int IDX_W  = 3,
    parameter int CTX_W  = 8,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 24,
    parameter int PERM_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         widx,
    input  logic [CTX_W-1:0]         w_ctx,
    input  logic [VPN_W-1:0]         w_vpn,
    input  logic [PFN_W-1:0]         w_pfn,
    input  logic [PERM_W-1:0]        w_perm,
    input  logic                     w_cach,
    input  logic                     w_mod,
    input  logic                     clr_all,
    input  logic [N-1:0]             clr_vec,
    output logic [N-1:0]             valid_o,
    output logic [N-1:0][CTX_W-1:0]  ctx_o,
    output logic [N-1:0][VPN_W-1:0]  vpn_o,
    output logic [N-1:0][PFN_W-1:0]  pfn_o,
    output logic [N-1:0][PERM_W-1:0] perm_o,
    output logic [N-1:0]             cach_o,
    output logic [N-1:0]             mod_o
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel;
        assign sel = we && (widx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_o[g] <= 1'b0;
            end else if (clr_all || clr_vec[g]) begin
                valid_o[g] <= 1'b0;
            end else if (sel) begin
                valid_o[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctx_o[g]  <= '0;
                vpn_o[g]  <= '0;
                pfn_o[g]  <= '0;
                perm_o[g] <= '0;
                cach_o[g] <= 1'b0;
                mod_o[g]  <= 1'b0;
            end else if (sel) begin
                ctx_o[g]  <= w_ctx;
                vpn_o[g]  <= w_vpn;
                pfn_o[g]  <= w_pfn;
                perm_o[g] <= w_perm;
                cach_o[g] <= w_cach;
                mod_o[g]  <= w_mod;
            end
        end
    end

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N     = 8,
    parameter int CTX_W = 8,
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PFN_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [CTX_W-1:0]       lk_ctx,
    input  logic [VA_W-1:0]        lk_vaddr,
    input  logic [1:0]             lk_acc,
    input  logic                   fl_valid,
    input  logic [CTX_W-1:0]       fl_ctx,
    input  logic [VA_W-OFF_W-1:0]  fl_vpn,
    input  logic [PFN_W-1:0]       fl_pfn,
    input  logic [2:0]             fl_perm,
    input  logic                   fl_cach,
    input  logic                   fl_mod,
    input  logic                   iv_all,
    input  logic                   iv_one,
    input  logic [CTX_W-1:0]       iv_ctx,
    input  logic [VA_W-OFF_W-1:0]  iv_vpn,
    output logic                   rs_valid,
    output logic                   rs_hit,
    output logic                   rs_miss,
    output logic                   rs_fault,
    output logic [PFN_W+OFF_W-1:0] rs_paddr,
    output logic                   rs_cacheable,
    output logic [CTX_W-1:0]       rs_ctx,
    output logic [VA_W-OFF_W-1:0]  rs_vpn
);

    localparam int VPN_W = VA_W - OFF_W;
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]             ent_valid;
    logic [N-1:0][CTX_W-1:0]  ent_ctx;
    logic [N-1:0][VPN_W-1:0]  ent_vpn;
    logic [N-1:0][PFN_W-1:0]  ent_pfn;
    logic [N-1:0][PERM_W-1:0] ent_perm;
    logic [N-1:0]             ent_cach;
    logic [N-1:0]             ent_mod;

    logic [N-1:0] lk_hit_vec;
    logic [N-1:0] fl_hit_vec;
    logic [N-1:0] iv_hit_vec;

    logic [VPN_W-1:0] lk_vpn;
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    ctx_tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_lk_match (
        .valid_vec (ent_valid),
        .ctx_arr   (ent_ctx),
        .vpn_arr   (ent_vpn),
        .key_ctx   (lk_ctx),
        .key_vpn   (lk_vpn),
        .hit_vec   (lk_hit_vec)
    );

    ctx_tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_fl_match (
        .valid_vec (ent_valid),
        .ctx_arr   (ent_ctx),
        .vpn_arr   (ent_vpn),
        .key_ctx   (fl_ctx),
        .key_vpn   (fl_vpn),
        .hit_vec   (fl_hit_vec)
    );

    ctx_tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_iv_match (
        .valid_vec (ent_valid),
        .ctx_arr   (ent_ctx),
        .vpn_arr   (ent_vpn),
        .key_ctx   (iv_ctx),
        .key_vpn   (iv_vpn),
        .hit_vec   (iv_hit_vec)
    );

    // Refill control: invalidate commands win, existing tags are rewritten in place.
    logic             fl_take;
    logic             fl_in_place;
    logic [IDX_W-1:0] fl_hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] fl_widx;
    logic             fl_alloc;

    always_comb begin
        fl_hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (fl_hit_vec[i]) begin
                fl_hit_idx = fl_hit_idx | IDX_W'(i);
            end
        end
    end

    assign fl_take     = fl_valid && !iv_all && !iv_one;
    assign fl_in_place = |fl_hit_vec;
    assign fl_alloc    = fl_take && !fl_in_place;
    assign fl_widx     = fl_in_place ? fl_hit_idx : victim_idx;

    ctx_tlb_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (ent_valid),
        .alloc      (fl_alloc),
        .victim_idx (victim_idx)
    );

    ctx_tlb_store #(
        .N(N), .IDX_W(IDX_W), .CTX_W(CTX_W), .VPN_W(VPN_W),
        .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (fl_take),
        .widx    (fl_widx),
        .w_ctx   (fl_ctx),
        .w_vpn   (fl_vpn),
        .w_pfn   (fl_pfn),
        .w_perm  (fl_perm),
        .w_cach  (fl_cach),
        .w_mod   (fl_mod),
        .clr_all (iv_all),
        .clr_vec (iv_one ? iv_hit_vec : '0),
        .valid_o (ent_valid),
        .ctx_o   (ent_ctx),
        .vpn_o   (ent_vpn),
        .pfn_o   (ent_pfn),
        .perm_o  (ent_perm),
        .cach_o  (ent_cach),
        .mod_o   (ent_mod)
    );

    // Selected entry for the lookup (one-hot OR mux).
    logic [PFN_W-1:0]  sel_pfn;
    logic [PERM_W-1:0] sel_perm;
    logic              sel_cach;
    logic              sel_mod;
    logic              lk_any;
    logic              perm_ok;

    always_comb begin
        sel_pfn  = '0;
        sel_perm = '0;
        sel_cach = 1'b0;
        sel_mod  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (lk_hit_vec[i]) begin
                sel_pfn  = sel_pfn  | ent_pfn[i];
                sel_perm = sel_perm | ent_perm[i];
                sel_cach = sel_cach | ent_cach[i];
                sel_mod  = sel_mod  | ent_mod[i];
            end
        end
    end

    assign lk_any = |lk_hit_vec;

    always_comb begin
        unique case (lk_acc)
            ACC_READ:  perm_ok = sel_perm[PERM_RD];
            ACC_WRITE: perm_ok = sel_perm[PERM_WR];
            ACC_EXEC:  perm_ok = sel_perm[PERM_EX];
            ACC_RSVD:  perm_ok = 1'b0;
            default:   perm_ok = 1'b0;
        endcase
    end

    // Response state machine.
    rsp_state_t state_q;
    rsp_state_t state_d;

    always_comb begin
        if (!lk_valid) begin
            state_d = RSP_IDLE;
        end else if (!lk_any) begin
            state_d = RSP_MISS;
        end else if (!perm_ok) begin
            state_d = RSP_FAULT;
        end else if ((lk_acc == ACC_WRITE) && !sel_mod) begin
            state_d = RSP_MISS;
        end else begin
            state_d = RSP_HIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [PFN_W-1:0] r_pfn;
    logic [OFF_W-1:0] r_off;
    logic             r_cach;
    logic [CTX_W-1:0] r_ctx;
    logic [VPN_W-1:0] r_vpn;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_pfn  <= '0;
            r_off  <= '0;
            r_cach <= 1'b0;
            r_ctx  <= '0;
            r_vpn  <= '0;
        end else if (lk_valid) begin
            r_pfn  <= sel_pfn;
            r_off  <= lk_vaddr[OFF_W-1:0];
            r_cach <= sel_cach;
            r_ctx  <= lk_ctx;
            r_vpn  <= lk_vpn;
        end
    end

    always_comb begin
        rs_valid     = 1'b0;
        rs_hit       = 1'b0;
        rs_miss      = 1'b0;
        rs_fault     = 1'b0;
        rs_paddr     = '0;
        rs_cacheable = 1'b0;
        rs_ctx       = r_ctx;
        rs_vpn       = r_vpn;
        unique case (state_q)
            RSP_IDLE: begin
                rs_ctx = '0;
                rs_vpn = '0;
            end
            RSP_HIT: begin
                rs_valid     = 1'b1;
                rs_hit       = 1'b1;
                rs_paddr     = {r_pfn, r_off};
                rs_cacheable = r_cach;
            end
            RSP_MISS: begin
                rs_valid = 1'b1;
                rs_miss  = 1'b1;
            end
            RSP_FAULT: begin
                rs_valid = 1'b1;
                rs_fault = 1'b1;
            end
            default: begin
                rs_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
    parameter int CTX_W = 8,
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PFN_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_valid,
    input logic [CTX_W-1:0]       lk_ctx,
    input logic [VA_W-1:0]        lk_vaddr,
    input logic [1:0]             lk_acc,
    input logic                   iv_all,
    input logic                   rs_valid,
    input logic                   rs_hit,
    input logic                   rs_miss,
    input logic                   rs_fault,
    input logic [PFN_W+OFF_W-1:0] rs_paddr,
    input logic [CTX_W-1:0]       rs_ctx,
    input logic [VA_W-OFF_W-1:0]  rs_vpn
);

    // R1
    req_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R1
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R1
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rs_hit, rs_miss, rs_fault}) && (rs_valid == (rs_hit || rs_miss || rs_fault)));

    // R2
    hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || (rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))));

    // R3
    echo_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> ((rs_vpn == $past(lk_vaddr[VA_W-1:OFF_W])) && (rs_ctx == $past(lk_ctx))));

    // R4
    rsvd_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_acc == 2'd3)) |=> !rs_hit);

    // R9
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iv_all ##1 lk_valid |=> !rs_hit);

endmodule

bind ctx_tlb ctx_tlb_chk #(
    .CTX_W(CTX_W), .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .lk_ctx   (lk_ctx),
    .lk_vaddr (lk_vaddr),
    .lk_acc   (lk_acc),
    .iv_all   (iv_all),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_miss  (rs_miss),
    .rs_fault (rs_fault),
    .rs_paddr (rs_paddr),
    .rs_ctx   (rs_ctx),
    .rs_vpn   (rs_vpn)
);

// File: tb/tb_ctx_tlb.sv
`timescale 1ns/1ps
module tb_ctx_tlb;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_ctx = '0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        fl_valid = 1'b0;
    logic [7:0]  fl_ctx = '0;
    logic [19:0] fl_vpn = '0;
    logic [23:0] fl_pfn = '0;
    logic [2:0]  fl_perm = '0;
    logic        fl_cach = 1'b0;
    logic        fl_mod = 1'b0;
    logic        iv_all = 1'b0;
    logic        iv_one = 1'b0;
    logic [7:0]  iv_ctx = '0;
    logic [19:0] iv_vpn = '0;
    logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_cacheable;
    logic [35:0] rs_paddr;
    logic [7:0]  rs_ctx;
    logic [19:0] rs_vpn;

    always #2 clk = ~clk;

    ctx_tlb dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ctx(lk_ctx), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .fl_valid(fl_valid), .fl_ctx(fl_ctx), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn),
        .fl_perm(fl_perm), .fl_cach(fl_cach), .fl_mod(fl_mod),
        .iv_all(iv_all), .iv_one(iv_one), .iv_ctx(iv_ctx), .iv_vpn(iv_vpn),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
        .rs_paddr(rs_paddr), .rs_cacheable(rs_cacheable), .rs_ctx(rs_ctx), .rs_vpn(rs_vpn)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the table, built from the requirements.
    bit          m_v    [N];
    logic [7:0]  m_ctx  [N];
    logic [19:0] m_vpn  [N];
    logic [23:0] m_pfn  [N];
    logic [2:0]  m_perm [N];
    bit          m_c    [N];
    bit          m_m    [N];
    int          m_rr = 0;

    // kind: 1 hit, 2 miss, 3 fault
    typedef struct {
        int          kind;
        logic [35:0] pa;
        bit          c;
        logic [7:0]  ctx;
        logic [19:0] vpn;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic do_refill(input logic [7:0] c, input logic [19:0] v, input logic [23:0] p,
                             input logic [2:0] pm, input bit ca, input bit md, input bit with_flush);
        int slot = -1;
        if (!with_flush) begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_ctx[i] == c && m_vpn[i] == v) slot = i;
            if (slot < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[slot] = 1; m_ctx[slot] = c; m_vpn[slot] = v; m_pfn[slot] = p;
            m_perm[slot] = pm; m_c[slot] = ca; m_m[slot] = md;
        end else begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end
        @(negedge clk);
        fl_valid = 1'b1; fl_ctx = c; fl_vpn = v; fl_pfn = p; fl_perm = pm;
        fl_cach = ca; fl_mod = md; iv_all = with_flush;
        @(negedge clk);
        fl_valid = 1'b0; iv_all = 1'b0;
    endtask

    task automatic do_inval_one(input logic [7:0] c, input logic [19:0] v);
        for (int i = 0; i < N; i++) if (m_v[i] && m_ctx[i] == c && m_vpn[i] == v) m_v[i] = 0;
        @(negedge clk);
        iv_one = 1'b1; iv_ctx = c; iv_vpn = v;
        @(negedge clk);
        iv_one = 1'b0;
    endtask

    task automatic do_lookup(input logic [7:0] c, input logic [31:0] va, input logic [1:0] acc,
                             input string req);
        exp_t e;
        int slot = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_ctx[i] == c && m_vpn[i] == va[31:12]) slot = i;
        e.ctx = c; e.vpn = va[31:12]; e.req = req; e.pa = '0; e.c = 0;
        if (slot < 0) e.kind = 2;
        else if (acc == 2'd3 || !m_perm[slot][acc]) e.kind = 3;
        else if (acc == 2'd1 && !m_m[slot]) e.kind = 2;
        else begin
            e.kind = 1; e.pa = {m_pfn[slot], va[11:0]}; e.c = m_c[slot];
        end
        sb.push_back(e);
        @(negedge clk);
        lk_valid = 1'b1; lk_ctx = c; lk_vaddr = va; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: compares each result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && rs_valid) begin
            int got;
            exp_t e;
            got = rs_hit ? 1 : (rs_miss ? 2 : (rs_fault ? 3 : 0));
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected result kind=%0d expected none", got);
            end else begin
                e = sb.pop_front();
                if (got != e.kind || rs_ctx != e.ctx || rs_vpn != e.vpn ||
                    (e.kind == 1 && (rs_paddr != e.pa || rs_cacheable != e.c))) begin
                    fails++;
                    $display("FAIL %s kind=%0d pa=%h c=%0d ctx=%h vpn=%h expected kind=%0d pa=%h c=%0d ctx=%h vpn=%h",
                             e.req, got, rs_paddr, rs_cacheable, rs_ctx, rs_vpn,
                             e.kind, e.pa, e.c, e.ctx, e.vpn);
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no result after reset
        checks++;
        if (rs_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 rs_valid=%b expected 0", rs_valid);
        end
        do_lookup(8'h01, 32'h0001_2345, 2'd0, "R1 empty table miss");

        // R2: context and page both matter
        do_refill(8'h01, 20'h00012, 24'hABCDE1, 3'b011, 1, 1, 0);
        do_lookup(8'h01, 32'h0001_2345, 2'd0, "R2 hit");
        do_lookup(8'h02, 32'h0001_2345, 2'd0, "R2 other ctx miss");
        do_lookup(8'h01, 32'h0001_3345, 2'd0, "R3 other page miss");

        // R4: permission faults
        do_refill(8'h02, 20'h00012, 24'h111111, 3'b101, 0, 0, 0);
        do_lookup(8'h02, 32'h0001_2FFF, 2'd2, "R4 exec allowed");
        do_lookup(8'h02, 32'h0001_2000, 2'd1, "R4 write denied");
        do_lookup(8'h01, 32'h0001_2010, 2'd2, "R4 exec denied");
        do_lookup(8'h01, 32'h0001_2010, 2'd3, "R4 reserved kind");

        // R5 and R8
        do_refill(8'h03, 20'h00400, 24'h222222, 3'b111, 1, 0, 0);
        do_lookup(8'h03, 32'h0040_0ABC, 2'd1, "R5 write to clean page");
        do_lookup(8'h03, 32'h0040_0ABC, 2'd0, "R5 read of clean page");
        do_refill(8'h03, 20'h00400, 24'h333333, 3'b111, 0, 1, 0);
        do_lookup(8'h03, 32'h0040_0ABC, 2'd1, "R8 in-place rewrite");

        // R10
        do_inval_one(8'h02, 20'h00012);
        do_lookup(8'h02, 32'h0001_2000, 2'd2, "R10 dropped entry");
        do_lookup(8'h01, 32'h0001_2000, 2'd0, "R10 other ctx kept");

        // R6 and R7: fill, then overflow
        for (int i = 0; i < 6; i++) do_refill(8'h05, 20'h00100 + 20'(i), 24'h500000 + 24'(i), 3'b001, 0, 1, 0);
        for (int i = 0; i < 6; i++) do_lookup(8'h05, {20'h00100 + 20'(i), 12'h004}, 2'd0, "R6 fill");
        do_refill(8'h05, 20'h00200, 24'h600000, 3'b001, 1, 1, 0);
        do_lookup(8'h05, 32'h0010_0004, 2'd0, "R7 evicted by pointer");
        do_lookup(8'h05, 32'h0020_0004, 2'd0, "R7 new entry");
        do_lookup(8'h01, 32'h0001_2004, 2'd0, "R7 survivor");
        do_refill(8'h05, 20'h00201, 24'h600001, 3'b001, 1, 1, 0);
        do_lookup(8'h03, 32'h0040_0004, 2'd0, "R7 second eviction");
        do_refill(8'h05, 20'h00101, 24'h700001, 3'b001, 1, 1, 0);
        do_refill(8'h05, 20'h00202, 24'h600002, 3'b001, 1, 1, 0);
        do_lookup(8'h05, 32'h0010_1004, 2'd0, "R8 pointer held");
        do_lookup(8'h05, 32'h0010_2004, 2'd0, "R8 next kept");
        do_inval_one(8'h05, 20'h00103);
        do_refill(8'h05, 20'h00203, 24'h600003, 3'b001, 0, 1, 0);
        do_lookup(8'h05, 32'h0020_3004, 2'd0, "R6 reuses freed slot");
        do_lookup(8'h05, 32'h0010_4004, 2'd0, "R6 pointer slot kept");

        // R9: flush with simultaneous refill
        do_refill(8'h09, 20'h00900, 24'h900000, 3'b111, 1, 1, 1);
        do_lookup(8'h09, 32'h0090_0000, 2'd0, "R9 refill dropped");
        do_lookup(8'h01, 32'h0001_2000, 2'd0, "R9 flushed");
        do_lookup(8'h05, 32'h0020_0000, 2'd0, "R9 flushed");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R1 pending results=%0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule